// File: doc/BRIEF.md
# Register-Window Operand Stack with Spill Memory

This block is the operand stack of a stack-machine datapath. The sixteen topmost entries are held in registers that the datapath reads in parallel every cycle; every deeper entry is parked in an internal spill array that the datapath cannot address. A push moves the whole window one slot deeper and sends the deepest register into the spill array. A pop moves the window one slot toward the top and brings the most recently spilled word back into the deepest register. The stack grows upward, so the spilled part always behaves as a last-in, first-out store.

The stack never holds fewer than sixteen elements. A hidden depth count tracks how many words sit in the spill array. A pop at the floor is refused with a one-cycle underflow fault, and a push with a full spill array is refused with a one-cycle overflow fault. Reset clears the upper eleven slots and seeds the five deepest slots from a digest input, so a program starts with its own fingerprint at the bottom of the stack.

Top module: `operand_stack`

## Requirements
- R1: While `rst` is high at a clock edge, window slots 0 to 10 become zero, slot 11+k takes digest word k (bits k*64+63 down to k*64 of `seedDigest`, k = 0..4), the spill array is emptied and both fault outputs are low after that edge.
- R2: A push alone (pushEn=1, popEn=0) with spill space left places `pushData` in slot 0 and moves each slot i to slot i+1 after the edge; slot i of `stackWin` is bits i*64+63 down to i*64.
- R3: A pop alone (popEn=1, pushEn=0) with at least one spilled word moves each slot i+1 to slot i after the edge and discards the old slot 0.
- R4: On a pop, slot 15 is refilled with the word most recently spilled by a push and not yet returned, so spilled words come back in reverse push order.
- R5: A pop alone with the spill array empty (sixteen elements) leaves the window and depth unchanged and raises `underflowFault` for the one cycle after that edge.
- R6: A push alone with 256 words spilled leaves the window and depth unchanged and raises `overflowFault` for the one cycle after that edge.
- R7: Push and pop together replace slot 0 with `pushData`, leave slots 1 to 15 and the depth unchanged and raise no fault, even at the floor or with the spill array full.
- R8: Each fault output is high only in the cycle after a refused operation; the two faults are never high together.
- R9: With neither push nor pop asserted, the window and depth hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; seeds the window |
| seedDigest | input | 320 | Five 64-bit digest words loaded into slots 11 to 15 on reset |
| pushEn | input | 1 | Push request |
| popEn | input | 1 | Pop request |
| pushData | input | 64 | Value pushed onto slot 0 |
| stackWin | output | 1024 | Sixteen visible slots, slot 0 in the low 64 bits |
| underflowFault | output | 1 | One-cycle pulse after a refused pop |
| overflowFault | output | 1 | One-cycle pulse after a refused push |

## Verification
Push and pop can be requested in the same cycle, and their coincidence must collapse into a replacement of the top slot instead of a shift in both directions or a fault. The bench provokes this inside the random stream, where both enables fall together about one cycle in eight, and in directed steps at the sixteen-element floor and with the spill array full, where either request alone would fault. Each such cycle is judged against a bench model that changes slot 0 only and keeps the depth, and later pops confirm that the spilled words were neither lost nor duplicated.

// File: rtl/opstack_pkg.sv
package opstack_pkg;

  // Strobes sent from the control to the window/spill datapath.
  typedef struct packed {
    logic seed;        // load reset pattern into the window
    logic shiftIn;     // push: window moves deeper, slot 15 spills
    logic shiftOut;    // pop: window moves up, slot 15 refills
    logic replaceTop;  // push and pop together: slot 0 overwritten
  } stackCmd_t;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } stackOp_t;

endpackage

// File: rtl/opstack_ctrl.sv
module opstack_ctrl
  import opstack_pkg::*;
#(
  parameter int SPILL_DEPTH = 256,
  localparam int DEPTH_W = $clog2(SPILL_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pushEn,
  input  logic               popEn,
  output stackCmd_t          cmd,
  output logic [DEPTH_W-1:0] spillDepth,
  output logic               underflowFault,
  output logic               overflowFault
);

  localparam logic [DEPTH_W-1:0] DEPTH_FULL = DEPTH_W'(SPILL_DEPTH);

  stackOp_t opKind;
  logic     spillEmpty;
  logic     spillFull;
  logic     pushOk;
  logic     popOk;

  always_comb begin
    opKind = stackOp_t'({popEn, pushEn});
  end

  assign spillEmpty = (spillDepth == '0);
  assign spillFull  = (spillDepth == DEPTH_FULL);
  assign pushOk     = (opKind == OP_PUSH) && !spillFull;
  assign popOk      = (opKind == OP_POP) && !spillEmpty;

  always_comb begin
    cmd            = '0;
    cmd.seed       = rst;
    cmd.shiftIn    = !rst && pushOk;
    cmd.shiftOut   = !rst && popOk;
    cmd.replaceTop = !rst && (opKind == OP_SWAP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spillDepth     <= '0;
      underflowFault <= 1'b0;
      overflowFault  <= 1'b0;
    end else begin
      underflowFault <= (opKind == OP_POP) && spillEmpty;
      overflowFault  <= (opKind == OP_PUSH) && spillFull;
      if (pushOk) begin
        spillDepth <= spillDepth + 1'b1;
      end else if (popOk) begin
        spillDepth <= spillDepth - 1'b1;
      end
    end
  end

endmodule

// File: rtl/opstack_dpath.sv
module opstack_dpath
  import opstack_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int WIN         = 16,
  parameter int SEED_N      = 5,
  parameter int SPILL_DEPTH = 256,
  localparam int DEPTH_W    = $clog2(SPILL_DEPTH + 1),
  localparam int ADDR_W     = (SPILL_DEPTH > 1) ? $clog2(SPILL_DEPTH) : 1,
  localparam int SEED_BASE  = WIN - SEED_N
) (
  input  logic                     clk,
  input  stackCmd_t                cmd,
  input  logic [DEPTH_W-1:0]       spillDepth,
  input  logic [SEED_N*DATA_W-1:0] seedDigest,
  input  logic [DATA_W-1:0]        pushData,
  output logic [WIN*DATA_W-1:0]    stackWin
);

  logic [DATA_W-1:0] winQ [WIN];
  logic [DATA_W-1:0] spillMem [SPILL_DEPTH];
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] refillWord;

  assign wrAddr     = ADDR_W'(spillDepth);
  assign rdAddr     = ADDR_W'(spillDepth - 1'b1);
  assign refillWord = spillMem[rdAddr];

  // Spill array: written by the word leaving the deepest slot.
  always_ff @(posedge clk) begin
    if (cmd.shiftIn) begin
      spillMem[wrAddr] <= winQ[WIN-1];
    end
  end

  for (genvar i = 0; i < WIN; i++) begin : g_slot
    logic [DATA_W-1:0] seedVal;
    logic [DATA_W-1:0] deeperVal;
    logic [DATA_W-1:0] shallowerVal;

    if (i >= SEED_BASE) begin : g_seeded
      assign seedVal = seedDigest[(i - SEED_BASE)*DATA_W +: DATA_W];
    end else begin : g_zeroed
      assign seedVal = '0;
    end

    if (i == 0) begin : g_top
      assign shallowerVal = pushData;
    end else begin : g_mid
      assign shallowerVal = winQ[i-1];
    end

    if (i == WIN - 1) begin : g_bottom
      assign deeperVal = refillWord;
    end else begin : g_upper
      assign deeperVal = winQ[i+1];
    end

    always_ff @(posedge clk) begin
      if (cmd.seed) begin
        winQ[i] <= seedVal;
      end else if (cmd.shiftIn) begin
        winQ[i] <= shallowerVal;
      end else if (cmd.shiftOut) begin
        winQ[i] <= deeperVal;
      end else if (cmd.replaceTop && (i == 0)) begin
        winQ[i] <= pushData;
      end
    end

    assign stackWin[i*DATA_W +: DATA_W] = winQ[i];
  end

endmodule

// File: rtl/operand_stack.sv
module operand_stack
  import opstack_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int WIN         = 16,
  parameter int SEED_N      = 5,
  parameter int SPILL_DEPTH = 256,
  localparam int DEPTH_W    = $clog2(SPILL_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SEED_N*DATA_W-1:0] seedDigest,
  input  logic                     pushEn,
  input  logic                     popEn,
  input  logic [DATA_W-1:0]        pushData,
  output logic [WIN*DATA_W-1:0]    stackWin,
  output logic                     underflowFault,
  output logic                     overflowFault
);

  stackCmd_t          cmd;
  logic [DEPTH_W-1:0] spillDepth;

  opstack_ctrl #(
    .SPILL_DEPTH(SPILL_DEPTH)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .pushEn        (pushEn),
    .popEn         (popEn),
    .cmd           (cmd),
    .spillDepth    (spillDepth),
    .underflowFault(underflowFault),
    .overflowFault (overflowFault)
  );

  opstack_dpath #(
    .DATA_W     (DATA_W),
    .WIN        (WIN),
    .SEED_N     (SEED_N),
    .SPILL_DEPTH(SPILL_DEPTH)
  ) u_dpath (
    .clk       (clk),
    .cmd       (cmd),
    .spillDepth(spillDepth),
    .seedDigest(seedDigest),
    .pushData  (pushData),
    .stackWin  (stackWin)
  );

endmodule

// File: rtl/operand_stack_chk.sv
module operand_stack_chk #(
  parameter int DATA_W      = 64,
  parameter int WIN         = 16,
  parameter int SPILL_DEPTH = 256,
  localparam int DEPTH_W    = $clog2(SPILL_DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  pushEn,
  input logic                  popEn,
  input logic [DATA_W-1:0]     pushData,
  input logic [WIN*DATA_W-1:0] stackWin,
  input logic [DEPTH_W-1:0]    spillDepth,
  input logic                  underflowFault,
  input logic                  overflowFault
);

  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(SPILL_DEPTH);

  // R1
  reset_clears_faults_chk: assert property (@(posedge clk)
    rst |=> (!underflowFault && !overflowFault && spillDepth == '0));

  // R2
  push_lands_on_top_chk: assert property (@(posedge clk) disable iff (rst)
    (pushEn && !popEn && spillDepth != FULL)
      |=> (stackWin[DATA_W-1:0] == $past(pushData)));

  // R3
  pop_moves_up_chk: assert property (@(posedge clk) disable iff (rst)
    (popEn && !pushEn && spillDepth != '0)
      |=> (stackWin[DATA_W-1:0] == $past(stackWin[2*DATA_W-1:DATA_W])));

  // R5
  floor_pop_faults_chk: assert property (@(posedge clk) disable iff (rst)
    (popEn && !pushEn && spillDepth == '0)
      |=> (underflowFault && $stable(stackWin)));

  // R6
  full_push_faults_chk: assert property (@(posedge clk) disable iff (rst)
    (pushEn && !popEn && spillDepth == FULL)
      |=> (overflowFault && $stable(stackWin)));

  // R7
  swap_keeps_depth_chk: assert property (@(posedge clk) disable iff (rst)
    (pushEn && popEn)
      |=> (spillDepth == $past(spillDepth) && !underflowFault && !overflowFault
           && stackWin[DATA_W-1:0] == $past(pushData)));

  // R8
  faults_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({underflowFault, overflowFault}));

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!pushEn && !popEn) |=> ($stable(stackWin) && $stable(spillDepth)));

endmodule

bind operand_stack operand_stack_chk #(
  .DATA_W     (DATA_W),
  .WIN        (WIN),
  .SPILL_DEPTH(SPILL_DEPTH)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .pushEn        (pushEn),
  .popEn         (popEn),
  .pushData      (pushData),
  .stackWin      (stackWin),
  .spillDepth    (spillDepth),
  .underflowFault(underflowFault),
  .overflowFault (overflowFault)
);

// File: tb/operand_stack_tb_top.sv
`timescale 1ns/1ps
module operand_stack_tb_top;

  localparam int DW    = 64;
  localparam int WIN   = 16;
  localparam int SEEDN = 5;
  localparam int SDEP  = 256;

  logic              clk = 1'b0;
  logic              rst;
  logic [SEEDN*DW-1:0] seedDigest;
  logic              pushEn;
  logic              popEn;
  logic [DW-1:0]     pushData;
  logic [WIN*DW-1:0] stackWin;
  logic              underflowFault;
  logic              overflowFault;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  // Bench model
  logic [DW-1:0] mWin [WIN];
  logic [DW-1:0] mSpill [SDEP];
  int            mDepth;
  bit            expU;
  bit            expO;

  always #10 clk = ~clk;  // 50 MHz

  operand_stack dut_i (
    .clk           (clk),
    .rst           (rst),
    .seedDigest    (seedDigest),
    .pushEn        (pushEn),
    .popEn         (popEn),
    .pushData      (pushData),
    .stackWin      (stackWin),
    .underflowFault(underflowFault),
    .overflowFault (overflowFault)
  );

  function automatic logic [DW-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic void modelReset();
    for (int i = 0; i < WIN; i++)
      mWin[i] = (i >= WIN - SEEDN) ? seedDigest[(i-(WIN-SEEDN))*DW +: DW] : '0;
    mDepth = 0;
    expU = 0;
    expO = 0;
  endfunction

  function automatic void modelStep(bit pu, bit po, logic [DW-1:0] d);
    expU = 0;
    expO = 0;
    if (pu && po) begin
      mWin[0] = d;
    end else if (pu) begin
      if (mDepth == SDEP) expO = 1;
      else begin
        mSpill[mDepth] = mWin[WIN-1];
        mDepth++;
        for (int i = WIN-1; i > 0; i--) mWin[i] = mWin[i-1];
        mWin[0] = d;
      end
    end else if (po) begin
      if (mDepth == 0) expU = 1;
      else begin
        for (int i = 0; i < WIN-1; i++) mWin[i] = mWin[i+1];
        mDepth--;
        mWin[WIN-1] = mSpill[mDepth];
      end
    end
  endfunction

  task automatic compare(string tag);
    bit bad = 0;
    for (int i = 0; i < WIN; i++) begin
      checks++;
      if (stackWin[i*DW +: DW] !== mWin[i]) begin
        errors++;
        bad = 1;
        $display("FAIL %s slot %0d actual %h expected %h", tag, i, stackWin[i*DW +: DW], mWin[i]);
      end
      if (bad) break;
    end
    checks++;
    if (underflowFault !== expU || overflowFault !== expO) begin
      errors++;
      $display("FAIL %s faults actual u=%b o=%b expected u=%b o=%b",
               tag, underflowFault, overflowFault, expU, expO);
    end
  endtask

  // Inputs set at negedge; result visible after posedge, checked at next negedge.
  task automatic step(bit pu, bit po, logic [DW-1:0] d);
    string tag;
    if (pu && po)                   tag = "R7 push+pop";
    else if (pu && mDepth == SDEP)  tag = "R6 overflow";
    else if (pu)                    tag = "R2 push";
    else if (po && mDepth == 0)     tag = "R5 underflow";
    else if (po)                    tag = "R3/R4 pop refill";
    else if (expU || expO)          tag = "R8 fault pulse";
    else                            tag = "R9 idle";
    pushEn = pu;
    popEn = po;
    pushData = d;
    modelStep(pu, po, d);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired actual %0d cycles expected fewer", cycles);
        finishRun();
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1;
    pushEn = 0;
    popEn = 0;
    pushData = '0;
    for (int k = 0; k < SEEDN; k++) seedDigest[k*DW +: DW] = rnd64();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    modelReset();
    compare("R1 reset seed");
    rst = 0;

    // Directed: floor behaviour right after reset
    step(0, 1, '0);          // R5 underflow
    step(0, 1, '0);          // R5 again, pulse stays one per refusal
    step(0, 0, '0);          // R8 pulse clears
    step(1, 1, rnd64());     // R7 at floor
    step(1, 0, rnd64());     // R2
    step(0, 1, '0);          // R4 digest word returns
    step(0, 1, '0);          // R5

    // Random mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 15);
      bit pu = (r < 7) || (r == 15) || (r == 14);
      bit po = ((r >= 7) && (r < 12)) || (r == 15) || (r == 14);
      step(pu, po, rnd64());
    end

    // Directed: fill spill array to the top
    while (mDepth < SDEP) step(1, 0, rnd64());
    step(1, 0, rnd64());     // R6 overflow
    step(1, 0, rnd64());     // R6 again
    step(1, 1, rnd64());     // R7 while full
    step(0, 0, '0);          // R8 clear
    // Directed: drain all the way, checking LIFO refill
    while (mDepth > 0) step(0, 1, '0);   // R4
    step(0, 1, '0);          // R5
    step(0, 0, '0);

    // Reset mid-run with new digest (R1)
    for (int k = 0; k < SEEDN; k++) seedDigest[k*DW +: DW] = rnd64();
    step(1, 0, rnd64());
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    modelReset();
    compare("R1 reseed");
    rst = 0;
    step(0, 1, '0);          // R5 floor restored
    finishRun();
  end

endmodule